// File: doc/BRIEF.md
# Indirect Load/Store Address Sequencer

This block carries out the register-indirect load and store instructions of a 16-bit processor. A start pulse hands it one instruction word. The block picks one of four memory pointers as the base address. It takes a signed offset either from a general register or from a second instruction word, and then forms the address of the access. Bit 3 decides whether the offset is added before the access. Bit 4 decides whether the pointer register is written back with pointer plus offset. Together these two bits give a plain access, an indexed access, post-increment and pre-increment.

The block shares one combinational read port and one write port with a register file. Indices 0 to 7 are the general registers and indices 8 to 11 are the pointers. Memory is a single-port synchronous RAM whose read data appears one cycle after the address. A side input can ask for up to eight consecutive registers to be moved to or from consecutive words.

The controller has the states IDLE, DECODE (read the pointer), GETIMM (take the immediate word), GETOFS (read the offset register), FORM (latch the access and update addresses), XFER (one cycle per word), LDLAST (write the last loaded word) and PTRWB (write the pointer back). The transitions are as follows:
- IDLE goes to DECODE on an accepted start.
- DECODE goes to GETIMM when the immediate form is used. Otherwise it goes to GETOFS when bit 4 or bit 3 is set, and to FORM when neither is set.
- GETIMM and GETOFS both go to FORM.
- FORM goes to XFER.
- XFER repeats until the last word. After the last word a load goes to LDLAST. A store goes to PTRWB when bit 4 is set, and to IDLE otherwise.
- LDLAST goes to PTRWB or IDLE, depending on bit 4.
- PTRWB goes to IDLE.

Top module: `ldst_seq`

## Requirements
- R1: A start is accepted only while idle and only when instr[15:13] is 011. Any other start leaves busy low and causes no register or memory write.
- R2: instr[2]=0 takes the offset from general register instr[7:5]. instr[2]=1 takes it from imm_word. imm_word is held from start until done.
- R3: With instr[3]=0 the first access goes to the pointer itself. With instr[3]=1 it goes to pointer plus offset. The offset is signed 16-bit and the sum wraps modulo 2^16.
- R4: With instr[4]=1 the selected pointer is written with pointer plus offset, whatever bit 3 is. With instr[4]=0 no pointer changes.
- R5: instr[1:0] selects the pointer at register index 8+instr[1:0], in the order PC=00, SP=01, FP=10, BP=11.
- R6: instr[12]=0 loads memory into the register and 1 stores the register to memory. instr[11]=0 names general register instr[10:8]. instr[11]=1 names pointer 8+instr[9:8].
- R7: With mw_en=1, words_m1+1 words move. Word k uses address A+k and register index instr[10:8]+k. The index wraps modulo 8 for general registers and modulo 4 for pointers.
- R8: busy stays high for 2+E+N+L+W cycles. E is 1 when instr[2], instr[3] or instr[4] is set, N is the word count, L is 1 for a load and W is instr[4]. done pulses once, in the last busy cycle.
- R9: When a load writes the pointer that is being updated, the loaded word stays and the pointer update is dropped.
- R10: The immediate form with instr[4:3]=00 gives the same result as the form without an offset, one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction |
| instr | input | 16 | First instruction word |
| imm_word | input | 16 | Second instruction word (immediate offset) |
| mw_en | input | 1 | Multi-word transfer enable |
| words_m1 | input | 3 | Word count minus one when mw_en is set |
| rf_rdata | input | 16 | Register-file read data (combinational) |
| mem_rdata | input | 16 | Memory read data, one cycle after address |
| rf_raddr | output | 4 | Register-file read index |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 4 | Register-file write index |
| rf_wdata | output | 16 | Register-file write data |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 16 | Memory write data |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Final cycle of the instruction |

## Verification
The start is sampled at one rising edge. busy rises after that edge, and the bench counts the busy cycles at falling edges until busy drops. The count must equal the R8 formula, and done must be seen in the last counted cycle only. A store's memory word is written at the edge that ends its XFER cycle. A loaded word reaches the register file one edge after its address. The pointer writeback lands at the edge that ends PTRWB. For this reason the register file and memory are compared only after busy has fallen, against values the bench derives from the instruction fields and the contents it loaded beforehand.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DECODE,
        S_GETIMM,
        S_GETOFS,
        S_FORM,
        S_XFER,
        S_LDLAST,
        S_PTRWB
    } seq_state_t;

    typedef struct packed {
        logic       is_store;
        logic       mp_class;
        logic [2:0] data_idx;
        logic [2:0] ofs_idx;
        logic       writeback;
        logic       pre_add;
        logic       use_imm;
        logic [1:0] ptr_sel;
    } ins_fields_t;

endpackage

// File: rtl/ldst_decode.sv
module ldst_decode
    import ldst_pkg::*;
(
    input  logic [15:0] word,
    output ins_fields_t fld,
    output logic        valid
);
    localparam logic [2:0] GROUP_OP = 3'b011;

    always_comb begin
        valid          = (word[15:13] == GROUP_OP);
        fld.is_store   = word[12];
        fld.mp_class   = word[11];
        fld.data_idx   = word[10:8];
        fld.ofs_idx    = word[7:5];
        fld.writeback  = word[4];
        fld.pre_add    = word[3];
        fld.use_imm    = word[2];
        fld.ptr_sel    = word[1:0];
    end
endmodule

// File: rtl/ldst_agen.sv
module ldst_agen #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] base,
    input  logic [DW-1:0] offset,
    input  logic          pre_add,
    output logic [DW-1:0] acc_addr,
    output logic [DW-1:0] upd_addr
);
    logic [DW-1:0] sum;

    always_comb begin
        sum      = base + offset;
        upd_addr = sum;
        acc_addr = pre_add ? sum : base;
    end
endmodule

// File: rtl/ldst_seq.sv
module ldst_seq
    import ldst_pkg::*;
#(
    parameter int DW = 16,
    parameter int IW = 3,
    parameter int PW = 2,
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [15:0]   instr,
    input  logic [DW-1:0] imm_word,
    input  logic          mw_en,
    input  logic [CW-1:0] words_m1,
    input  logic [DW-1:0] rf_rdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [IW:0]   rf_raddr,
    output logic          rf_we,
    output logic [IW:0]   rf_waddr,
    output logic [DW-1:0] rf_wdata,
    output logic [DW-1:0] mem_addr,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    output logic          busy,
    output logic          done
);
    localparam int RAW = IW + 1;

    seq_state_t    state, nxt;
    ins_fields_t   dec, fld;
    logic          dec_valid;
    logic [DW-1:0] base_q, off_q, addr_q, upd_q;
    logic [DW-1:0] acc_a, upd_a;
    logic [CW-1:0] k_q, last_q;
    logic [RAW-1:0] ld_waddr_q, ptr_addr, cur_addr;
    logic [IW-1:0] cur_idx;
    logic          ptr_hit_q, last_word;

    function automatic logic [RAW-1:0] reg_addr(input logic cls, input logic [IW-1:0] i);
        return cls ? {1'b1, {(IW-PW){1'b0}}, i[PW-1:0]} : {1'b0, i};
    endfunction

    ldst_decode u_dec (
        .word  (instr),
        .fld   (dec),
        .valid (dec_valid)
    );

    ldst_agen #(.DW(DW)) u_agen (
        .base     (base_q),
        .offset   (off_q),
        .pre_add  (fld.pre_add),
        .acc_addr (acc_a),
        .upd_addr (upd_a)
    );

    assign ptr_addr  = {1'b1, {(IW-PW){1'b0}}, fld.ptr_sel};
    assign cur_idx   = fld.data_idx + IW'(k_q);
    assign cur_addr  = reg_addr(fld.mp_class, cur_idx);
    assign last_word = (k_q == last_q);

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (start && dec_valid) nxt = S_DECODE;
            S_DECODE: begin
                if (fld.use_imm)                        nxt = S_GETIMM;
                else if (fld.writeback || fld.pre_add)  nxt = S_GETOFS;
                else                                    nxt = S_FORM;
            end
            S_GETIMM: nxt = S_FORM;
            S_GETOFS: nxt = S_FORM;
            S_FORM:   nxt = S_XFER;
            S_XFER: begin
                if (last_word) begin
                    if (!fld.is_store)      nxt = S_LDLAST;
                    else if (fld.writeback) nxt = S_PTRWB;
                    else                    nxt = S_IDLE;
                end
            end
            S_LDLAST: nxt = fld.writeback ? S_PTRWB : S_IDLE;
            S_PTRWB:  nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            fld        <= '0;
            base_q     <= '0;
            off_q      <= '0;
            addr_q     <= '0;
            upd_q      <= '0;
            k_q        <= '0;
            last_q     <= '0;
            ld_waddr_q <= '0;
            ptr_hit_q  <= 1'b0;
        end else begin
            state <= nxt;
            unique case (state)
                S_IDLE: begin
                    if (start && dec_valid) begin
                        fld       <= dec;
                        last_q    <= mw_en ? words_m1 : '0;
                        ptr_hit_q <= 1'b0;
                    end
                end
                S_DECODE: begin
                    base_q <= rf_rdata;
                    off_q  <= '0;
                end
                S_GETIMM: off_q <= imm_word;
                S_GETOFS: off_q <= rf_rdata;
                S_FORM: begin
                    addr_q <= acc_a;
                    upd_q  <= upd_a;
                    k_q    <= '0;
                end
                S_XFER: begin
                    k_q        <= k_q + 1'b1;
                    ld_waddr_q <= cur_addr;
                    if (!fld.is_store && cur_addr == ptr_addr) ptr_hit_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        busy      = (state != S_IDLE);
        done      = 1'b0;
        rf_raddr  = '0;
        rf_we     = 1'b0;
        rf_waddr  = '0;
        rf_wdata  = '0;
        mem_addr  = '0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        unique case (state)
            S_DECODE: rf_raddr = ptr_addr;
            S_GETOFS: rf_raddr = {1'b0, fld.ofs_idx};
            S_XFER: begin
                mem_addr = addr_q + DW'(k_q);
                if (fld.is_store) begin
                    rf_raddr  = cur_addr;
                    mem_we    = 1'b1;
                    mem_wdata = rf_rdata;
                    done      = last_word && !fld.writeback;
                end else if (k_q != '0) begin
                    rf_we    = 1'b1;
                    rf_waddr = ld_waddr_q;
                    rf_wdata = mem_rdata;
                end
            end
            S_LDLAST: begin
                rf_we    = 1'b1;
                rf_waddr = ld_waddr_q;
                rf_wdata = mem_rdata;
                done     = !fld.writeback;
            end
            S_PTRWB: begin
                rf_we    = !ptr_hit_q;
                rf_waddr = ptr_addr;
                rf_wdata = upd_q;
                done     = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ldst_seq_chk.sv
module ldst_seq_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [15:0]   instr,
    input logic          busy,
    input logic          done,
    input logic          mem_we,
    input logic [DW-1:0] mem_addr,
    input logic          rf_we
);
    p_no_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && instr[15:13] != 3'b011) |=> !busy);

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_we && !rf_we && !done));

    p_done_final_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + 1'b1));

    p_store_no_rfw_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !rf_we);
endmodule

bind ldst_seq ldst_seq_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .instr    (instr),
    .busy     (busy),
    .done     (done),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .rf_we    (rf_we)
);

// File: tb/sim_ldst_seq.sv
module sim_ldst_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] instr = '0;
    logic [15:0] imm_word = '0;
    logic        mw_en = 1'b0;
    logic [2:0]  words_m1 = '0;
    logic [15:0] rf_rdata, mem_rdata;
    logic [3:0]  rf_raddr, rf_waddr;
    logic        rf_we, mem_we, busy, done;
    logic [15:0] rf_wdata, mem_addr, mem_wdata;

    logic [15:0] rf  [0:11];
    logic [15:0] mem [0:65535];
    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    ldst_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .imm_word(imm_word), .mw_en(mw_en), .words_m1(words_m1),
        .rf_rdata(rf_rdata), .mem_rdata(mem_rdata), .rf_raddr(rf_raddr),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .busy(busy), .done(done)
    );

    assign rf_rdata = (rf_raddr < 4'd12) ? rf[rf_raddr] : 16'h0000;

    always @(posedge clk) begin
        mem_rdata <= mem[mem_addr];
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (rf_we && rf_waddr < 4'd12) rf[rf_waddr] <= rf_wdata;
    end

    function automatic logic [15:0] init_val(input int i);
        case (i)
            0: return 16'h0005;  1: return 16'hFFFD;
            2: return 16'h1234;  3: return 16'h8000;
            4: return 16'h7FFF;  5: return 16'h0010;
            6: return 16'hFFFF;  7: return 16'h00A0;
            8: return 16'hFFFC;  9: return 16'h0100;
            10: return 16'h7FFF; default: return 16'h8000;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [15:0] ins, input logic [15:0] immv,
                          input logic mwen, input logic [2:0] wm1, input string req);
        logic [15:0] rf0 [0:11];
        logic [15:0] rfe [0:11];
        logic [15:0] mv  [0:7];
        logic [15:0] base, off, acc, upd;
        logic ld, cls, wb, pre, im, hit, lastd;
        logic [2:0] di, oi;
        logic [1:0] p;
        int n, lat, cnt, dn, ra;
        @(negedge clk);
        for (int i = 0; i < 12; i++) begin
            rf[i]  = init_val(i);
            rf0[i] = init_val(i);
        end
        ld = !ins[12]; cls = ins[11]; di = ins[10:8]; oi = ins[7:5];
        wb = ins[4]; pre = ins[3]; im = ins[2]; p = ins[1:0];
        base = rf0[8 + p];
        off  = im ? immv : rf0[oi];
        upd  = base + off;
        acc  = pre ? upd : base;
        n    = mwen ? int'(wm1) + 1 : 1;
        for (int k = 0; k < 8; k++) mv[k] = mem[acc + 16'(k)];
        for (int i = 0; i < 12; i++) rfe[i] = rf0[i];
        hit = 1'b0;
        if (ld) begin
            for (int k = 0; k < n; k++) begin
                ra = cls ? 8 + ((int'(di) + k) % 4) : (int'(di) + k) % 8;
                rfe[ra] = mv[k];
                if (cls && ra == 8 + int'(p)) hit = 1'b1;
            end
        end
        if (wb && !hit) rfe[8 + p] = upd;
        lat = 2 + int'(im | wb | pre) + n + int'(ld) + int'(wb);
        instr = ins; imm_word = immv; mw_en = mwen; words_m1 = wm1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 0; dn = 0; lastd = 1'b0;
        while (busy && cnt < 64) begin
            cnt++;
            if (done) dn++;
            lastd = done;
            @(negedge clk);
        end
        check(cnt == lat, "R8", "busy cycles", 16'(cnt), 16'(lat));
        check(dn == 1 && lastd, "R8", "done pulse count", 16'(dn), 16'd1);
        for (int i = 0; i < 12; i++)
            check(rf[i] === rfe[i], req, $sformatf("reg %0d ins %h", i, ins), rf[i], rfe[i]);
        if (!ld) begin
            for (int k = 0; k < n; k++) begin
                ra = cls ? 8 + ((int'(di) + k) % 4) : (int'(di) + k) % 8;
                check(mem[acc + 16'(k)] === rf0[ra], req,
                      $sformatf("mem word %0d ins %h", k, ins), mem[acc + 16'(k)], rf0[ra]);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int a = 0; a < 65536; a++) mem[a] = 16'(a) * 16'h9E37 ^ 16'h5A5A;
        for (int i = 0; i < 12; i++) rf[i] = init_val(i);
        repeat (3) @(negedge clk);
        check(!busy && !done && !rf_we && !mem_we, "R8", "reset outputs",
              {12'h0, busy, done, rf_we, mem_we}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: foreign opcode must not start
        instr = 16'hE5A4; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 3; c++) begin
            check(!busy && !rf_we && !mem_we, "R1", "foreign opcode ignored",
                  {13'h0, busy, rf_we, mem_we}, 16'h0000);
            @(negedge clk);
        end

        // Sweep of every single-word mode, register class and pointer: R2 R3 R4 R5 R6 R10
        for (int st = 0; st < 2; st++)
            for (int cls = 0; cls < 2; cls++)
                for (int md = 0; md < 8; md++)
                    for (int p = 0; p < 4; p++) begin
                        logic [2:0] di, oi;
                        di = 3'((p * 3 + md + cls) % 8);
                        oi = 3'((md + st * 2 + 1) % 8);
                        run_op({3'b011, 1'(st), 1'(cls), di, oi, 3'(md), 2'(p)},
                               16'h8003 + 16'(md * 7), 1'b0, 3'd0, "R2/R3/R4/R5/R6/R10");
                    end

        // R7: multi-word lengths for both directions and classes
        for (int st = 0; st < 2; st++)
            for (int cls = 0; cls < 2; cls++)
                for (int w = 0; w < 8; w++)
                    run_op({3'b011, 1'(st), 1'(cls), 3'd6, 3'd5, 3'b110, 2'(w % 4)},
                           16'h0004, 1'b1, 3'(w), "R7");

        // R9: load into the pointer that is being post-updated
        run_op({3'b011, 1'b0, 1'b1, 3'd1, 3'd0, 3'b100, 2'd1}, 16'h0000, 1'b0, 3'd0, "R9");
        run_op({3'b011, 1'b0, 1'b1, 3'd2, 3'd0, 3'b111, 2'd3}, 16'hFFF0, 1'b1, 3'd2, "R9");

        // R10: immediate form with no indexing matches plain form
        run_op({3'b011, 1'b0, 1'b0, 3'd3, 3'd0, 3'b001, 2'd2}, 16'h1111, 1'b0, 3'd0, "R10");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule